// File: doc/BRIEF.md
# Display serial link frame monitor

This block passively observes a four-wire, write-only serial display link: an active-low select, a serial clock, a serial data line and a line that marks each byte as either a command or a parameter. The four link wires are brought into a faster system clock through synchronisers. The block rebuilds each byte, tags it as a command or a parameter and reports it on a one-cycle strobe.

It also groups the parameter bytes that follow each command into one transaction. A transaction is closed only when the next command byte arrives. At that point a one-cycle close strobe carries the finished opcode, its parameter count, an overflow flag and a flag that says whether the opcode belongs to a small recognised set.

The parameters of the most recently closed transaction can be read back by index while the next transaction collects its own parameters. Parameter bytes seen before the first command belong to no transaction. They are only counted. The link clock must run at no more than a quarter of the system clock.

Top module: `dspi_frame_mon`

## Requirements
- R1: Bits are assembled most significant bit first. After the eighth bit, `byte_vld_o` is high for exactly one system cycle with the byte on `byte_o`. This strobe comes 3 system cycles after the falling link-clock transition of that eighth bit.
- R2: Each bit takes the value `sdi_i` had at the rising link-clock edge. A change of `sdi_i` while `sclk_i` is high does not alter the byte.
- R3: While `cs_ni` is high, no bits are taken and no byte strobe occurs. A partially received byte is discarded when `cs_ni` goes high.
- R4: The tag is the value of `dc_i` at the eighth falling edge. A value of 0 gives a command (`byte_is_data_o`=0) and a value of 1 gives a parameter (`byte_is_data_o`=1). Earlier values of `dc_i` within the byte have no effect.
- R5: A command byte closes the open transaction. `txn_vld_o` is high for one cycle, exactly one cycle after that command's byte strobe, and `txn_op_o` holds the previous opcode. The new command then opens a transaction with no parameters.
- R6: `txn_cnt_o` is the number of parameters received, saturating at MAX_PARAMS (128). Only the first MAX_PARAMS parameters are stored. `txn_ovf_o` is 1 if more than MAX_PARAMS parameters arrived, and 0 otherwise.
- R7: A command followed directly by another command is reported with `txn_cnt_o`=0 and `txn_ovf_o`=0.
- R8: `txn_known_o` is 1 exactly for the opcodes 0x2C, 0x01, 0x3A, 0x2A, 0x00 and 0x2B, and 0 for all other opcodes.
- R9: `rd_data_o` shows parameter number `rd_idx_i` (starting at 0) of the most recently closed transaction. The value holds until the next close, even while new parameters arrive.
- R10: Before the first command after reset, no transaction is open. Parameter bytes seen then increment `orphan_cnt_o` (saturating) and are not stored. The first command produces no close strobe. `orphan_cnt_o` does not change once a transaction is open.
- R11: During and right after reset, `byte_vld_o`, `txn_vld_o` and `orphan_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Link select, active low |
| sclk_i | input | 1 | Link serial clock |
| sdi_i | input | 1 | Link serial data |
| dc_i | input | 1 | Link command (0) / parameter (1) select |
| byte_vld_o | output | 1 | One-cycle strobe per received byte |
| byte_o | output | 8 | Received byte |
| byte_is_data_o | output | 1 | 1 for a parameter byte, 0 for a command |
| txn_vld_o | output | 1 | One-cycle strobe on transaction close |
| txn_op_o | output | 8 | Opcode of the closed transaction |
| txn_cnt_o | output | CNT_W (8) | Parameter count, saturating at MAX_PARAMS |
| txn_ovf_o | output | 1 | More parameters than could be stored |
| txn_known_o | output | 1 | Opcode is in the recognised set |
| rd_idx_i | input | IDX_W (7) | Parameter index for readback |
| rd_data_o | output | 8 | Stored parameter of the last closed transaction |
| orphan_cnt_o | output | ORPH_W (8) | Parameter bytes seen before the first command |

## Verification
The byte strobe is due exactly three system cycles after the bench drives the final falling link-clock transition of a byte: two synchroniser stages and then the output register. The close strobe follows its command's byte strobe by exactly one cycle. The bench keeps a cycle counter, records the cycle of each final falling transition and of each command strobe, and checks both distances exactly. All outputs are sampled on the falling system-clock edge. Readback is combinational, so it is checked shortly after the index is driven, between edges.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] dbyte_t;

  function automatic logic op_known(dbyte_t op);
    case (op)
      8'h00, 8'h01, 8'h2A, 8'h2B, 8'h2C, 8'h3A: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dspi_byte_rx.sv
module dspi_byte_rx
  import dspi_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cs_s_i,
  input  logic   sclk_s_i,
  input  logic   sdi_s_i,
  input  logic   dc_s_i,
  output logic   byte_vld_o,
  output dbyte_t byte_o,
  output logic   is_data_o
);
  localparam int unsigned BC_W = $clog2(BYTE_W);

  logic            sclk_q, bit_q, bit_vld_q;
  logic [BC_W-1:0] cnt_q;
  dbyte_t          shreg_q;
  logic            rise, fall;

  assign rise = sclk_s_i & ~sclk_q;
  assign fall = ~sclk_s_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      bit_q      <= 1'b0;
      bit_vld_q  <= 1'b0;
      cnt_q      <= '0;
      shreg_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      is_data_o  <= 1'b0;
    end else begin
      sclk_q     <= sclk_s_i;
      byte_vld_o <= 1'b0;
      if (cs_s_i) begin
        bit_vld_q <= 1'b0;
        cnt_q     <= '0;
      end else if (rise) begin
        bit_q     <= sdi_s_i;
        bit_vld_q <= 1'b1;
      end else if (fall && bit_vld_q) begin
        bit_vld_q <= 1'b0;
        if (cnt_q == BC_W'(BYTE_W-1)) begin
          cnt_q      <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= {shreg_q[BYTE_W-2:0], bit_q};
          is_data_o  <= dc_s_i;
        end else begin
          cnt_q   <= cnt_q + BC_W'(1);
          shreg_q <= {shreg_q[BYTE_W-2:0], bit_q};
        end
      end
    end
  end

  p_cs_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !byte_vld_o);
  p_single_byte_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  p_byte_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(sclk_q) && !sclk_q);
endmodule

// File: rtl/dspi_txn_grp.sv
module dspi_txn_grp
  import dspi_pkg::*;
#(
  parameter int unsigned MAX_PARAMS = 128,
  parameter int unsigned ORPH_W     = 8,
  localparam int unsigned CNT_W = $clog2(MAX_PARAMS + 1),
  localparam int unsigned IDX_W = $clog2(MAX_PARAMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  dbyte_t           byte_i,
  input  logic             is_data_i,
  output logic             txn_vld_o,
  output dbyte_t           txn_op_o,
  output logic [CNT_W-1:0] txn_cnt_o,
  output logic             txn_ovf_o,
  output logic             txn_known_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output dbyte_t           rd_data_o,
  output logic [ORPH_W-1:0] orphan_cnt_o
);
  localparam int unsigned DEPTH = 2 * MAX_PARAMS;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic             open_q, ovf_q, bank_q;
  dbyte_t           op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ORPH_W-1:0] orphan_q;
  dbyte_t           mem_q [DEPTH];
  logic             full, wr_en;
  logic [AW-1:0]    wr_addr, rd_addr;

  assign full    = (cnt_q == CNT_W'(MAX_PARAMS));
  assign wr_en   = byte_vld_i & is_data_i & open_q & ~full;
  // two banks: writer fills bank_q, reader sees the other (last closed) one
  assign wr_addr = AW'(bank_q ? MAX_PARAMS : 0) + AW'(cnt_q);
  assign rd_addr = AW'(bank_q ? 0 : MAX_PARAMS) + AW'(rd_idx_i);

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_addr] <= byte_i;
  end

  assign rd_data_o    = mem_q[rd_addr];
  assign orphan_cnt_o = orphan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= 1'b0;
      ovf_q       <= 1'b0;
      bank_q      <= 1'b0;
      op_q        <= '0;
      cnt_q       <= '0;
      orphan_q    <= '0;
      txn_vld_o   <= 1'b0;
      txn_op_o    <= '0;
      txn_cnt_o   <= '0;
      txn_ovf_o   <= 1'b0;
      txn_known_o <= 1'b0;
    end else begin
      txn_vld_o <= 1'b0;
      if (byte_vld_i) begin
        if (!is_data_i) begin
          if (open_q) begin
            txn_vld_o   <= 1'b1;
            txn_op_o    <= op_q;
            txn_cnt_o   <= cnt_q;
            txn_ovf_o   <= ovf_q;
            txn_known_o <= op_known(op_q);
            bank_q      <= ~bank_q;
          end
          open_q <= 1'b1;
          op_q   <= byte_i;
          cnt_q  <= '0;
          ovf_q  <= 1'b0;
        end else if (open_q) begin
          if (full) ovf_q <= 1'b1;
          else      cnt_q <= cnt_q + CNT_W'(1);
        end else if (orphan_q != '1) begin
          orphan_q <= orphan_q + ORPH_W'(1);
        end
      end
    end
  end

  p_cnt_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_PARAMS));
  p_ovf_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_vld_o && txn_ovf_o) |-> txn_cnt_o == CNT_W'(MAX_PARAMS));
  p_close_on_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_vld_o |-> $past(byte_vld_i && !is_data_i));
  p_single_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_vld_o |=> !txn_vld_o);
  p_no_close_before_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |-> !txn_vld_o && cnt_q == '0);
  p_orphan_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |=> $stable(orphan_q));
endmodule

// File: rtl/dspi_frame_mon.sv
module dspi_frame_mon
  import dspi_pkg::*;
#(
  parameter int unsigned MAX_PARAMS  = 128,
  parameter int unsigned ORPH_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = $clog2(MAX_PARAMS + 1),
  localparam int unsigned IDX_W = $clog2(MAX_PARAMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              dc_i,
  output logic              byte_vld_o,
  output logic [7:0]        byte_o,
  output logic              byte_is_data_o,
  output logic              txn_vld_o,
  output logic [7:0]        txn_op_o,
  output logic [CNT_W-1:0]  txn_cnt_o,
  output logic              txn_ovf_o,
  output logic              txn_known_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic [ORPH_W-1:0] orphan_cnt_o
);
  logic [3:0] link_s;

  // bit order {dc, sdi, sclk, cs}; select idles high
  dspi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dc_i, sdi_i, sclk_i, cs_ni}),
    .q_o   (link_s)
  );

  dbyte_t rx_byte;
  logic   rx_vld, rx_is_data;

  dspi_byte_rx i_byte_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (link_s[0]),
    .sclk_s_i  (link_s[1]),
    .sdi_s_i   (link_s[2]),
    .dc_s_i    (link_s[3]),
    .byte_vld_o(rx_vld),
    .byte_o    (rx_byte),
    .is_data_o (rx_is_data)
  );

  assign byte_vld_o     = rx_vld;
  assign byte_o         = rx_byte;
  assign byte_is_data_o = rx_is_data;

  dspi_txn_grp #(.MAX_PARAMS(MAX_PARAMS), .ORPH_W(ORPH_W)) i_txn_grp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (rx_vld),
    .byte_i      (rx_byte),
    .is_data_i   (rx_is_data),
    .txn_vld_o   (txn_vld_o),
    .txn_op_o    (txn_op_o),
    .txn_cnt_o   (txn_cnt_o),
    .txn_ovf_o   (txn_ovf_o),
    .txn_known_o (txn_known_o),
    .rd_idx_i    (rd_idx_i),
    .rd_data_o   (rd_data_o),
    .orphan_cnt_o(orphan_cnt_o)
  );
endmodule

// File: tb/test_dspi_frame_mon.sv
module test_dspi_frame_mon;
  localparam int MAXP = 128;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk_i = 1'b0, sdi_i = 1'b0, dc_i = 1'b0;
  logic       byte_vld_o, byte_is_data_o, txn_vld_o, txn_ovf_o, txn_known_o;
  logic [7:0] byte_o, txn_op_o, rd_data_o, orphan_cnt_o;
  logic [7:0] txn_cnt_o;
  logic [6:0] rd_idx_i = '0;

  int checks = 0, errors = 0, cyc = 0;
  int last_fall_cyc = 0, cmd_cyc = 0;
  logic [9:0] exp_b [1024];
  int nb_exp = 0, nb_got = 0;
  logic [7:0] t_op [256];
  int t_cnt [256];
  logic t_ovf [256], t_kn [256];
  int nt_exp = 0, nt_got = 0;
  logic m_open = 1'b0;
  logic [7:0] m_op = '0;
  int m_cnt = 0, orph_exp = 0;
  logic [7:0] cur_p [MAXP];
  logic [7:0] prev_p [MAXP];
  int unsigned seed_dummy;

  dspi_frame_mon i_dspi_frame_mon (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .sdi_i(sdi_i), .dc_i(dc_i),
    .byte_vld_o(byte_vld_o), .byte_o(byte_o), .byte_is_data_o(byte_is_data_o),
    .txn_vld_o(txn_vld_o), .txn_op_o(txn_op_o), .txn_cnt_o(txn_cnt_o),
    .txn_ovf_o(txn_ovf_o), .txn_known_o(txn_known_o),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .orphan_cnt_o(orphan_cnt_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic known_f(input logic [7:0] op);
    return op == 8'h2C || op == 8'h01 || op == 8'h3A ||
           op == 8'h2A || op == 8'h00 || op == 8'h2B;
  endfunction

  // one byte on the link; dc_a for early bits, dc_b from the last bit on
  task automatic send_byte(input logic dc_a, input logic dc_b, input logic [7:0] val,
                           input logic glitch);
    for (int i = 7; i >= 0; i--) begin
      dc_i  = (i == 0) ? dc_b : dc_a;
      sdi_i = val[i];
      repeat (HALF) @(negedge clk);
      sclk_i = 1'b1;
      repeat (2) @(negedge clk);
      if (glitch) sdi_i = ~val[i];
      repeat (HALF - 2) @(negedge clk);
      sclk_i = 1'b0;
      if (i == 0) begin
        exp_b[nb_exp] = {glitch, dc_b, val};
        nb_exp++;
        last_fall_cyc = cyc;
      end
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic dc_a);
    if (m_open) begin
      t_op[nt_exp]  = m_op;
      t_cnt[nt_exp] = (m_cnt > MAXP) ? MAXP : m_cnt;
      t_ovf[nt_exp] = (m_cnt > MAXP);
      t_kn[nt_exp]  = known_f(m_op);
      nt_exp++;
      for (int k = 0; k < MAXP; k++) prev_p[k] = cur_p[k];
    end
    m_open = 1'b1;
    m_op   = op;
    m_cnt  = 0;
    send_byte(dc_a, 1'b0, op, 1'b0);
  endtask

  task automatic send_par(input logic [7:0] v, input logic dc_a, input logic glitch);
    if (m_open) begin
      if (m_cnt < MAXP) cur_p[m_cnt] = v;
      m_cnt++;
    end else if (orph_exp < 255) begin
      orph_exp++;
    end
    send_byte(dc_a, 1'b1, v, glitch);
  endtask

  task automatic chk_rd(input int idx, input logic [7:0] exp);
    rd_idx_i = 7'(idx);
    #1;
    chk("R9", int'(rd_data_o), int'(exp), $sformatf("readback idx %0d", idx));
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_ni && byte_vld_o) begin
      if (nb_got >= nb_exp) begin
        chk("R3", nb_got, nb_exp, "unexpected byte strobe");
      end else begin
        chk(exp_b[nb_got][9] ? "R2" : "R1", int'(byte_o), int'(exp_b[nb_got][7:0]), "byte value");
        chk("R4", int'(byte_is_data_o), int'(exp_b[nb_got][8]), "byte tag");
        chk("R1", cyc - last_fall_cyc, 3, "byte strobe latency");
      end
      nb_got++;
      if (!byte_is_data_o) cmd_cyc = cyc;
    end
    if (rst_ni && txn_vld_o) begin
      if (nt_got >= nt_exp) begin
        chk("R10", nt_got, nt_exp, "unexpected close strobe");
      end else begin
        chk("R5", cyc - cmd_cyc, 1, "close latency");
        chk("R5", int'(txn_op_o), int'(t_op[nt_got]), "opcode");
        chk(t_cnt[nt_got] == 0 ? "R7" : "R6", int'(txn_cnt_o), t_cnt[nt_got], "count");
        chk("R6", int'(txn_ovf_o), int'(t_ovf[nt_got]), "overflow");
        chk("R8", int'(txn_known_o), int'(t_kn[nt_got]), "known flag");
      end
      nt_got++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: cycles=%0d expected below %0d", cyc, 200000);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R11", int'(byte_vld_o), 0, "byte strobe in reset");
    chk("R11", int'(txn_vld_o), 0, "close strobe in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11", int'(orphan_cnt_o), 0, "orphan count after reset");
    cs_ni = 1'b0;
    repeat (HALF) @(negedge clk);

    // R10: parameters before any command
    for (int i = 0; i < 3; i++) send_par(8'(8'h40 + i), 1'b1, 1'b0);
    chk("R10", int'(orphan_cnt_o), 3, "orphan count");
    send_cmd(8'h2A, 1'b0);
    send_par(8'h00, 1'b1, 1'b0);
    send_par(8'h10, 1'b1, 1'b0);
    send_par(8'h00, 1'b1, 1'b0);
    send_par(8'h7F, 1'b1, 1'b0);
    send_cmd(8'h2C, 1'b0);
    for (int i = 0; i < 10; i++) send_par(8'($urandom), 1'b1, 1'b0);
    // R9: closed parameters stay while new ones arrive
    chk_rd(0, 8'h00); chk_rd(1, 8'h10); chk_rd(2, 8'h00); chk_rd(3, 8'h7F);
    for (int i = 0; i < 120; i++) send_par(8'($urandom), 1'b1, 1'b0);
    send_cmd(8'h00, 1'b0);       // R6 overflow close
    chk_rd(0, prev_p[0]); chk_rd(64, prev_p[64]); chk_rd(127, prev_p[127]);
    send_cmd(8'h77, 1'b0);       // R7 empty transaction
    send_par(8'hA5, 1'b1, 1'b1); // R2 data change while clock high
    send_par(8'h3C, 1'b0, 1'b0); // R4 dc low early, high at the end
    send_cmd(8'h3A, 1'b1);       // R4 dc high early, low at the end
    send_par(8'h55, 1'b1, 1'b0);

    // R3: partial byte aborted by select, clocks ignored while deselected
    for (int i = 0; i < 5; i++) begin
      sdi_i = 1'b1; repeat (HALF) @(negedge clk);
      sclk_i = 1'b1; repeat (HALF) @(negedge clk);
      sclk_i = 1'b0; repeat (HALF) @(negedge clk);
    end
    cs_ni = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_i = 1'b1; repeat (HALF) @(negedge clk);
      sclk_i = 1'b0; repeat (HALF) @(negedge clk);
    end
    chk("R3", nb_got, nb_exp, "no strobe while deselected");
    cs_ni = 1'b0;
    repeat (HALF) @(negedge clk);
    send_par(8'h81, 1'b1, 1'b0);

    // random traffic mixing recognised and unrecognised opcodes
    for (int n = 0; n < 30; n++) begin
      logic [7:0] op;
      int np;
      case ($urandom_range(0, 2))
        0: op = 8'h2B;
        1: op = 8'h01;
        default: op = 8'($urandom);
      endcase
      send_cmd(op, 1'($urandom));
      np = $urandom_range(0, 5);
      for (int k = 0; k < np; k++) send_par(8'($urandom), 1'($urandom), 1'($urandom));
    end
    send_cmd(8'h01, 1'b0);
    for (int k = 0; k < m_cnt; k++) ;
    repeat (10) @(negedge clk);
    chk("R3", nb_got, nb_exp, "total byte strobes");
    chk("R5", nt_got, nt_exp, "total close strobes");
    chk("R10", int'(orphan_cnt_o), orph_exp, "orphan count frozen");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule